// File: doc/BRIEF.md
# Audio Sample Pair Rate Adapter

This block moves stereo audio sample pairs from the domain of a serial audio receiver's bit clock into a local domain driven by a separate master oscillator. The two oscillators are free-running and nominally equal. They may differ by a few tens of parts per million, so over time one side runs ahead of the other. Each incoming left/right pair is stored as one unit in an eight-entry dual-clock buffer. The buffer's write and read positions cross between the domains as Gray-coded pointers through two-flop synchronizers.

The read side divides its master clock, which runs at 256 times the sample rate, to produce one output frame strobe per sample period. It presents one pair with each strobe. After reset the read side outputs silence until the buffer has filled halfway. From then on, an empty buffer at a strobe makes it replay the previous pair. A write that arrives while all eight entries are occupied is thrown away. Drift is therefore absorbed by repeating or discarding whole pairs, never by splitting a word. Two saturating event counters expose how often each correction happened.

Top module: `audio_rate_adapter`

## Requirements
- R1: While either reset is low and after it is released, `rd_left`, `rd_right`, `rd_frame`, `rd_repeat_count` and `wr_drop_count` are all zero until the first read frame strobe.
- R2: `rd_frame` is high for exactly one `rd_clk` cycle once every FRAME_DIV `rd_clk` cycles (default 256). `rd_left` and `rd_right` change only in a cycle in which `rd_frame` is high.
- R3: Until a strobe finds at least DEPTH/2 (four) stored pairs, every strobe presents a zero pair and the repeat counter stays at zero.
- R4: Once output has started, each strobe that finds a stored pair presents the oldest unread pair. Left and right come from the same write, with all 24 bits of each word unchanged, in write order.
- R5: Once output has started, a strobe that finds no stored pair presents the previous pair again, and `rd_repeat_count` rises by one. The repeat counter changes only at a strobe.
- R6: A write that arrives while DEPTH (eight) pairs are stored is discarded, and `wr_drop_count` rises by one. The pairs already stored are read out later unchanged and in order. The drop counter changes only in the cycle after `wr_valid` was high.
- R7: After the buffer has run empty, a single new write is presented at the next strobe, and no second halfway fill is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receiver-side clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_valid | input | 1 | One-cycle pulse: a new pair is on wr_left/wr_right |
| wr_left | input | 24 | Left channel sample to store |
| wr_right | input | 24 | Right channel sample to store |
| wr_drop_count | output | 16 | Saturating count of discarded writes (write domain) |
| rd_clk | input | 1 | Master clock at FRAME_DIV times the sample rate |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_frame | output | 1 | One-cycle strobe marking a new output pair |
| rd_left | output | 24 | Left channel sample presented with rd_frame |
| rd_right | output | 24 | Right channel sample presented with rd_frame |
| rd_repeat_count | output | 16 | Saturating count of replayed frames (read domain) |

## Verification
The bench first withholds writes and then feeds three pairs. This separates the silent start-up phase from normal reading. A run of one write per frame, with counting, inverted and alternating bit patterns, shows that left and right stay paired and in order and that no bits are torn between words. Stopping the writes drains the buffer into repeats, and a single write afterwards shows that output resumes without a second halfway fill. A twelve-write burst placed between two strobes overfills the buffer, which shows that the newest writes are the ones dropped and that the eight kept pairs survive intact.

// File: rtl/audio_ra_pkg.sv
// Shared helpers for the audio rate adapter: pointer code conversion and
// the read-side start-up state. Assumes pointers are at most 32 bits wide.
package audio_ra_pkg;

    // Read side: silent until the first halfway fill, then normal reading
    typedef enum logic {
        RD_PRIMING = 1'b0,
        RD_RUNNING = 1'b1
    } rd_state_t;

    // Binary to reflected Gray code
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/ra_gray_sync.sv
// Two-flop synchronizer for a Gray-coded pointer. Assumes the source
// changes at most one bit per source clock, so every captured value is a
// real pointer value.
module ra_gray_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    // Capture the foreign pointer, then retime it once more
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/ra_pair_store.sv
// Dual-clock storage of left/right pairs, one word per entry. Writes are
// registered on wr_clk. The read is combinational at raddr and is only
// used for entries that were written several read cycles earlier.
module ra_pair_store #(
    parameter int DATA_W = 48,
    parameter int DEPTH  = 8,
    parameter int AW     = 3
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a whole pair in one write
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the entry at the read pointer
    always_comb begin
        rdata = mem[raddr];
    end

endmodule

// File: rtl/ra_write_ctrl.sv
// Write-domain control. It accepts a pair when the buffer has space and
// discards it when all entries are taken, as judged against the
// synchronized read pointer. Assumes DEPTH is a power of two.
module ra_write_ctrl
    import audio_ra_pkg::*;
#(
    parameter int AW    = 3,
    parameter int PW    = AW + 1,
    parameter int CNT_W = 16
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_valid,
    input  logic [PW-1:0]    rgray_sync,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wgray,
    output logic [CNT_W-1:0] drop_count
);

    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin_sync;
    logic [PW-1:0] wbin_next;
    logic          full;

    // Decode the read pointer and test for an all-occupied buffer
    always_comb begin
        rbin_sync = PW'(gray_to_bin(32'(rgray_sync)));
        full      = (wbin[AW] != rbin_sync[AW]) && (wbin[AW-1:0] == rbin_sync[AW-1:0]);
        we        = wr_valid && !full;
        waddr     = wbin[AW-1:0];
        wbin_next = wbin + 1'b1;
    end

    // Advance the write pointer on accepted pairs
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_next;
            wgray <= PW'(bin_to_gray(32'(wbin_next)));
        end
    end

    // Count discarded pairs, holding at the top value
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            drop_count <= '0;
        end else if (wr_valid && full && (drop_count != '1)) begin
            drop_count <= drop_count + 1'b1;
        end
    end

endmodule

// File: rtl/ra_read_ctrl.sv
// Read-domain control. It divides the master clock into frame strobes and
// holds silence until the buffer is half full. After that it pops one pair
// per strobe, or replays the last pair when the synchronized fill is zero.
module ra_read_ctrl
    import audio_ra_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int DEPTH     = 8,
    parameter int AW        = 3,
    parameter int PW        = AW + 1,
    parameter int FRAME_DIV = 256,
    parameter int CNT_W     = 16
) (
    input  logic                  rd_clk,
    input  logic                  rd_rst_n,
    input  logic [PW-1:0]         wgray_sync,
    input  logic [2*SAMPLE_W-1:0] rdata,
    output logic [AW-1:0]         raddr,
    output logic [PW-1:0]         rgray,
    output logic                  frame,
    output logic [SAMPLE_W-1:0]   out_left,
    output logic [SAMPLE_W-1:0]   out_right,
    output logic [CNT_W-1:0]      repeat_count
);

    localparam int DIV_W = (FRAME_DIV > 2) ? $clog2(FRAME_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FRAME_DIV - 1);
    localparam logic [PW-1:0]    HALF     = PW'(DEPTH / 2);

    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    logic [PW-1:0]    rbin;
    logic [PW-1:0]    rbin_next;
    logic [PW-1:0]    wbin_sync;
    logic [PW-1:0]    fill;
    rd_state_t        state;

    // Fill level as seen from the read domain
    always_comb begin
        wbin_sync = PW'(gray_to_bin(32'(wgray_sync)));
        fill      = wbin_sync - rbin;
        rbin_next = rbin + 1'b1;
        raddr     = rbin[AW-1:0];
        tick      = (div_cnt == DIV_LAST);
    end

    // Master clock divider that paces the output frames
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Per-frame decision: stay silent, pop a pair or replay the last one
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            state        <= RD_PRIMING;
            frame        <= 1'b0;
            rbin         <= '0;
            rgray        <= '0;
            out_left     <= '0;
            out_right    <= '0;
            repeat_count <= '0;
        end else begin
            frame <= tick;
            if (tick) begin
                if ((state == RD_RUNNING) && (fill == '0)) begin
                    if (repeat_count != '1) begin
                        repeat_count <= repeat_count + 1'b1;
                    end
                end else if ((state == RD_RUNNING) || (fill >= HALF)) begin
                    state     <= RD_RUNNING;
                    out_left  <= rdata[2*SAMPLE_W-1:SAMPLE_W];
                    out_right <= rdata[SAMPLE_W-1:0];
                    rbin      <= rbin_next;
                    rgray     <= PW'(bin_to_gray(32'(rbin_next)));
                end
            end
        end
    end

endmodule

// File: rtl/audio_rate_adapter.sv
// Top of the sample pair rate adapter. It joins the storage, the two pointer
// synchronizers and the per-domain controls. Assumes DEPTH is a power of two
// of at least 4 and that wr_valid is a pulse per received pair.
module audio_rate_adapter #(
    parameter int SAMPLE_W  = 24,
    parameter int DEPTH     = 8,
    parameter int FRAME_DIV = 256,
    parameter int CNT_W     = 16
) (
    input  logic                wr_clk,
    input  logic                wr_rst_n,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    output logic [CNT_W-1:0]    wr_drop_count,
    input  logic                rd_clk,
    input  logic                rd_rst_n,
    output logic                rd_frame,
    output logic [SAMPLE_W-1:0] rd_left,
    output logic [SAMPLE_W-1:0] rd_right,
    output logic [CNT_W-1:0]    rd_repeat_count
);

    localparam int AW     = $clog2(DEPTH);
    localparam int PW     = AW + 1;
    localparam int PAIR_W = 2 * SAMPLE_W;

    logic              we;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [PAIR_W-1:0] rdata;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_sync;
    logic [PW-1:0]     rgray_sync;

    ra_pair_store #(
        .DATA_W (PAIR_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) u_store (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  ({wr_left, wr_right}),
        .raddr  (raddr),
        .rdata  (rdata)
    );

    ra_gray_sync #(.W(PW)) u_rptr_to_wr (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rgray),
        .q     (rgray_sync)
    );

    ra_gray_sync #(.W(PW)) u_wptr_to_rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wgray),
        .q     (wgray_sync)
    );

    ra_write_ctrl #(
        .AW    (AW),
        .PW    (PW),
        .CNT_W (CNT_W)
    ) u_wctl (
        .wr_clk     (wr_clk),
        .wr_rst_n   (wr_rst_n),
        .wr_valid   (wr_valid),
        .rgray_sync (rgray_sync),
        .we         (we),
        .waddr      (waddr),
        .wgray      (wgray),
        .drop_count (wr_drop_count)
    );

    ra_read_ctrl #(
        .SAMPLE_W  (SAMPLE_W),
        .DEPTH     (DEPTH),
        .AW        (AW),
        .PW        (PW),
        .FRAME_DIV (FRAME_DIV),
        .CNT_W     (CNT_W)
    ) u_rctl (
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .wgray_sync   (wgray_sync),
        .rdata        (rdata),
        .raddr        (raddr),
        .rgray        (rgray),
        .frame        (rd_frame),
        .out_left     (rd_left),
        .out_right    (rd_right),
        .repeat_count (rd_repeat_count)
    );

endmodule

// File: rtl/ra_adapter_checker.sv
// Port-level temporal checks for the rate adapter, attached by bind.
module ra_adapter_checker #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 16
) (
    input logic                wr_clk,
    input logic                wr_rst_n,
    input logic                wr_valid,
    input logic [CNT_W-1:0]    wr_drop_count,
    input logic                rd_clk,
    input logic                rd_rst_n,
    input logic                rd_frame,
    input logic [SAMPLE_W-1:0] rd_left,
    input logic [SAMPLE_W-1:0] rd_right,
    input logic [CNT_W-1:0]    rd_repeat_count
);

    // R2
    strobe_single_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_frame |=> !rd_frame);

    // R2
    hold_between_frames_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_frame |-> ($stable(rd_left) && $stable(rd_right)));

    // R5
    repeat_only_at_frame_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_frame |-> $stable(rd_repeat_count));

    // R5
    repeat_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_frame |-> ((rd_repeat_count == $past(rd_repeat_count)) ||
                      (rd_repeat_count == CNT_W'($past(rd_repeat_count) + 1'b1))));

    // R6
    drop_after_write_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !$past(wr_valid) |-> $stable(wr_drop_count));

endmodule

bind audio_rate_adapter ra_adapter_checker #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W)
) u_checker (
    .wr_clk          (wr_clk),
    .wr_rst_n        (wr_rst_n),
    .wr_valid        (wr_valid),
    .wr_drop_count   (wr_drop_count),
    .rd_clk          (rd_clk),
    .rd_rst_n        (rd_rst_n),
    .rd_frame        (rd_frame),
    .rd_left         (rd_left),
    .rd_right        (rd_right),
    .rd_repeat_count (rd_repeat_count)
);

// File: tb/audio_rate_adapter_test.sv
`timescale 1ns/1ps
module audio_rate_adapter_test;

    localparam int SW    = 24;
    localparam int DEPTH = 8;
    localparam int DIV   = 32;
    localparam int CW    = 16;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [SW-1:0] wr_left = '0;
    logic [SW-1:0] wr_right = '0;
    logic [CW-1:0] wr_drop_count;
    logic          rd_frame;
    logic [SW-1:0] rd_left;
    logic [SW-1:0] rd_right;
    logic [CW-1:0] rd_repeat_count;

    audio_rate_adapter #(
        .SAMPLE_W (SW), .DEPTH (DEPTH), .FRAME_DIV (DIV), .CNT_W (CW)
    ) uut (
        .wr_clk (wr_clk), .wr_rst_n (wr_rst_n), .wr_valid (wr_valid),
        .wr_left (wr_left), .wr_right (wr_right), .wr_drop_count (wr_drop_count),
        .rd_clk (rd_clk), .rd_rst_n (rd_rst_n), .rd_frame (rd_frame),
        .rd_left (rd_left), .rd_right (rd_right), .rd_repeat_count (rd_repeat_count)
    );

    always #10   rd_clk = ~rd_clk;   // 50 MHz master side
    always #10.4 wr_clk = ~wr_clk;   // slightly slower receiver side

    logic [2*SW-1:0] exp_q[$];
    logic [2*SW-1:0] last_pair = '0;
    bit    started = 0;
    bit    mon_en = 0;
    bit    done = 0;
    int    exp_rep = 0;
    int    exp_drop = 0;
    int    tests = 0;
    int    fails = 0;
    string pop_req = "R4";

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    function automatic logic [2*SW-1:0] make_pair(input int i);
        logic [SW-1:0] l;
        logic [SW-1:0] r;
        case (i % 4)
            0: begin l = SW'(i * 24'h010203); r = ~l; end
            1: begin l = 24'hAAAAAA ^ SW'(i); r = 24'h555555 ^ SW'(i << 8); end
            2: begin l = 24'hFFFFFF - SW'(i); r = SW'(i); end
            default: begin l = 24'h800001 | SW'(i << 4); r = 24'h7FFFFE & ~SW'(i); end
        endcase
        return {l, r};
    endfunction

    // Driver: one pair per call, pushing what the design must keep
    task automatic drive_pair(input logic [2*SW-1:0] p, input bit hold);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_left  = p[2*SW-1:SW];
        wr_right = p[SW-1:0];
        if (exp_q.size() == DEPTH) exp_drop++;
        else exp_q.push_back(p);
        if (!hold) begin
            @(negedge wr_clk);
            wr_valid = 1'b0;
        end
    endtask

    task automatic wait_frame();
        do @(negedge rd_clk); while (!rd_frame);
        repeat (5) @(negedge wr_clk);
    endtask

    // Monitor: compare every frame against the scoreboard model
    always @(negedge rd_clk) begin
        if (mon_en && rd_rst_n && rd_frame) begin
            if (!started && exp_q.size() >= DEPTH / 2) started = 1;
            if (!started) begin
                check({rd_left, rd_right} == '0, "R3", 64'({rd_left, rd_right}), 64'd0);
                check(rd_repeat_count == '0, "R3", 64'(rd_repeat_count), 64'd0);
            end else if (exp_q.size() > 0) begin
                last_pair = exp_q.pop_front();
                check({rd_left, rd_right} == last_pair, pop_req, 64'({rd_left, rd_right}), 64'(last_pair));
                check(int'(rd_repeat_count) == exp_rep, pop_req, 64'(rd_repeat_count), 64'(exp_rep));
            end else begin
                exp_rep++;
                check({rd_left, rd_right} == last_pair, "R5", 64'({rd_left, rd_right}), 64'(last_pair));
                check(int'(rd_repeat_count) == exp_rep, "R5", 64'(rd_repeat_count), 64'(exp_rep));
            end
        end
    end

    initial begin
        #(200000 * 20);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        repeat (6) @(negedge rd_clk);
        rd_rst_n = 1'b1;
        wr_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        // R1: quiet outputs after reset
        check({rd_left, rd_right} == '0, "R1", 64'({rd_left, rd_right}), 64'd0);
        check(rd_frame == 1'b0, "R1", 64'(rd_frame), 64'd0);
        check(rd_repeat_count == '0, "R1", 64'(rd_repeat_count), 64'd0);
        check(wr_drop_count == '0, "R1", 64'(wr_drop_count), 64'd0);
        mon_en = 1;

        // R2: strobe spacing
        do @(negedge rd_clk); while (!rd_frame);
        n = 0;
        do begin @(negedge rd_clk); n++; end while (!rd_frame);
        check(n == DIV, "R2", 64'(n), 64'(DIV));

        // R3: three pairs are not enough to start
        for (int i = 0; i < 3; i++) begin
            wait_frame();
            drive_pair(make_pair(i), 0);
        end
        wait_frame();
        wait_frame();
        // R4: fourth pair starts playback, then one write per frame
        drive_pair(make_pair(3), 0);
        for (int i = 4; i < 24; i++) begin
            wait_frame();
            drive_pair(make_pair(i), 0);
        end

        // R5: stop writing and let the buffer run dry
        for (int i = 0; i < 9; i++) wait_frame();
        check(rd_repeat_count != '0, "R5", 64'(rd_repeat_count), 64'(exp_rep));

        // R7: one write after running dry plays at the next frame
        drive_pair(make_pair(100), 0);
        do @(negedge rd_clk); while (!rd_frame);
        check({rd_left, rd_right} == make_pair(100), "R7", 64'({rd_left, rd_right}), 64'(make_pair(100)));
        repeat (5) @(negedge wr_clk);
        drive_pair(make_pair(101), 0);
        wait_frame();
        drive_pair(make_pair(102), 0);

        // R6: burst of twelve between two strobes overfills the buffer
        wait_frame();
        for (int i = 0; i < 12; i++) drive_pair(make_pair(200 + i), 1);
        @(negedge wr_clk);
        wr_valid = 1'b0;
        repeat (2) @(negedge wr_clk);
        check(int'(wr_drop_count) == exp_drop, "R6", 64'(wr_drop_count), 64'(exp_drop));
        check(exp_drop > 0, "R6", 64'(exp_drop), 64'd1);
        pop_req = "R6";
        for (int i = 0; i < 11; i++) wait_frame();
        check(exp_q.size() == 0, "R6", 64'(exp_q.size()), 64'd0);
        check(int'(wr_drop_count) == exp_drop, "R6", 64'(wr_drop_count), 64'(exp_drop));
        finish_run();
    end

endmodule